// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block is the host-visible register store of an interrupt routing controller. The host bus sees only two locations: a select register and a data window. Software writes an index into the select register and then reads or writes the window. Behind the window are three small registers: an identification register, a constant version register and a read-only mirror of the identification value. There is also a routing table with one 64-bit entry per interrupt pin. Each entry is reached as two 32-bit halves.

The block keeps the routing table. It drives every entry's fields in parallel to the pin logic that sits next to it. It accepts in-service set and clear requests from that logic. After every accepted table write it emits a one-cycle update strobe that carries the entry number, so the pin logic can re-evaluate that pin. Interrupt generation, delivery and error reporting belong to other blocks.

Top module: `ind_route_regs`

## Requirements
- R1: Only the low 8 bits of `bus_addr` are decoded. Offset 0x00 is the select register, which reads back the last accepted 32-bit value. Offset 0x10 is the data window. Every other offset reads 0 and ignores writes. Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.
- R2: Select index 0x01 reads `{8'h00, NPINS-1, 8'h00, VER_CODE}`, which is 0x00170011 with the default parameters. Writes to this index are discarded.
- R3: Select index 0x00 holds a 4-bit ID, written from and read in bits 27:24, with all other bits reading 0. Index 0x02 reads the same value, and writes to it are discarded.
- R4: A select value s ≥ 0x10 addresses table entry (s − 0x10) >> 1. An even s reaches bits 31:0 of the entry and an odd s reaches bits 63:32.
- R5: Bit 14 of an entry is the in-service flag, and the bus cannot write it. Any write to the low half of an entry forces the flag to 0.
- R6: A write to the high half of an entry leaves that entry's in-service flag unchanged.
- R7: A window access whose entry number is NPINS or more, or whose select value is 0x03 to 0x0F, reads 0, changes nothing and raises no update strobe.
- R8: After reset every entry has its mask bit (bit 16) set and every other bit 0. The select register and the ID are 0.
- R9: A write to either location is accepted only when `bus_size` is 4 or 8. The block uses the low 32 bits of the data. Writes of any other size are ignored.
- R10: The cycle after an accepted table write, `upd_valid` is 1 for one cycle and `upd_index` carries the entry number. `upd_valid` is 0 in every other cycle.
- R11: The field outputs of each entry are: vector = bits 7:0, delivery mode = 10:8, destination mode = 11, polarity = 13, in-service = 14, trigger = 15, mask = 16, destination = 63:56.
- R12: A one-cycle pulse on `svc_set[n]` sets the flag of entry n, and a pulse on `svc_clr[n]` clears it. A clear beats a set in the same cycle, and a low-half bus write beats both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus byte address, only bits 7:0 decoded |
| bus_wr | input | 1 | Write request, one cycle |
| bus_rd | input | 1 | Read request, one cycle |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| svc_set | input | NPINS | Per-entry in-service set pulse |
| svc_clr | input | NPINS | Per-entry in-service clear pulse |
| ent_vector | output | NPINS×8 | Vector field per entry |
| ent_dlv_mode | output | NPINS×3 | Delivery mode field per entry |
| ent_dst_mode | output | NPINS | Destination mode bit per entry |
| ent_polarity | output | NPINS | Polarity bit per entry |
| ent_inservice | output | NPINS | In-service flag per entry |
| ent_trigger | output | NPINS | Trigger mode bit per entry |
| ent_mask | output | NPINS | Mask bit per entry |
| ent_dest | output | NPINS×8 | Destination field per entry |
| upd_valid | output | 1 | Entry-updated strobe |
| upd_index | output | IDX_W | Entry number for the strobe |

## Verification
Every state change lands on the clock edge that samples the request. A write therefore shows on the field outputs and on `upd_valid` one edge after `bus_wr`, and a read result shows on `bus_rdata` one edge after `bus_rd`. The bench drives each request on a falling edge and removes it on the next falling edge. It samples at that second falling edge, after exactly one rising edge, so each check looks at the cycle in which its result is due. The update strobe is also checked at that same point to confirm it is absent after ignored writes. In-service pulses are checked one edge after they are applied.

// File: rtl/ixr_pkg.sv
package ixr_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  localparam logic [31:0] IDX_ID   = 32'h0000_0000;
  localparam logic [31:0] IDX_VER  = 32'h0000_0001;
  localparam logic [31:0] IDX_ARB  = 32'h0000_0002;
  localparam logic [31:0] IDX_TAB0 = 32'h0000_0010;

  localparam int B_VEC_LO = 0;
  localparam int B_DLV_LO = 8;
  localparam int B_DSTM   = 11;
  localparam int B_POL    = 13;
  localparam int B_SVC    = 14;
  localparam int B_TRIG   = 15;
  localparam int B_MASK   = 16;
  localparam int B_DEST_LO = 24; // inside the high half
  localparam int B_ID_LO  = 24;

  typedef enum logic [2:0] {
    TGT_ID, TGT_VER, TGT_ARB, TGT_TAB, TGT_NONE
  } tgt_e;

  function automatic logic size_ok(input logic [3:0] sz);
    return (sz == 4'd4) || (sz == 4'd8);
  endfunction

  function automatic logic [31:0] entry_of(input logic [31:0] sel);
    return (sel - IDX_TAB0) >> 1;
  endfunction

  function automatic logic [31:0] ver_word(input int unsigned npins,
                                           input logic [7:0] code);
    return {8'h00, 8'(npins - 1), 8'h00, code};
  endfunction

  function automatic logic [31:0] lo_reset();
    logic [31:0] v;
    v = '0;
    v[B_MASK] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/ixr_sel_decode.sv
module ixr_sel_decode
  import ixr_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic [31:0]      sel,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);
  logic [31:0] ent;

  always_comb begin
    ent = entry_of(sel);
    idx = ent[IDX_W-1:0];
    hi  = sel[0];
    if (sel == IDX_ID)       tgt = TGT_ID;
    else if (sel == IDX_VER) tgt = TGT_VER;
    else if (sel == IDX_ARB) tgt = TGT_ARB;
    else if (sel >= IDX_TAB0 && ent < 32'(NPINS)) tgt = TGT_TAB;
    else                     tgt = TGT_NONE;
  end
endmodule

// File: rtl/ixr_table.sv
module ixr_table
  import ixr_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_hi,
  input  logic [31:0]            wr_data,
  input  logic [NPINS-1:0]       svc_set,
  input  logic [NPINS-1:0]       svc_clr,
  output logic [NPINS-1:0][31:0] tbl_lo,
  output logic [NPINS-1:0][31:0] tbl_hi
);
  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic        hit;
    logic [31:0] lo_q, hi_q, lo_n;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      lo_n = lo_q;
      if (svc_set[g]) lo_n[B_SVC] = 1'b1;
      if (svc_clr[g]) lo_n[B_SVC] = 1'b0;
      if (hit && !wr_hi) begin
        lo_n = wr_data;
        lo_n[B_SVC] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= lo_reset();
        hi_q <= '0;
      end else begin
        lo_q <= lo_n;
        if (hit && wr_hi) hi_q <= wr_data;
      end
    end

    assign tbl_lo[g] = lo_q;
    assign tbl_hi[g] = hi_q;
  end
endmodule

// File: rtl/ixr_readmux.sv
module ixr_readmux
  import ixr_pkg::*;
#(
  parameter int          NPINS    = 24,
  parameter logic [7:0]  VER_CODE = 8'h11,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic [7:0]             off,
  input  logic [31:0]            sel_q,
  input  logic [3:0]             id_q,
  input  tgt_e                   tgt,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   hi,
  input  logic [NPINS-1:0][31:0] tbl_lo,
  input  logic [NPINS-1:0][31:0] tbl_hi,
  output logic [31:0]            word
);
  logic [31:0] win;

  always_comb begin
    unique case (tgt)
      TGT_ID, TGT_ARB: win = {4'h0, id_q, 24'h0};
      TGT_VER:         win = ver_word(NPINS, VER_CODE);
      TGT_TAB:         win = hi ? tbl_hi[idx] : tbl_lo[idx];
      default:         win = '0;
    endcase
    if (off == OFS_SEL)      word = sel_q;
    else if (off == OFS_WIN) word = win;
    else                     word = '0;
  end
endmodule

// File: rtl/ind_route_regs.sv
module ind_route_regs
  import ixr_pkg::*;
#(
  parameter int         NPINS    = 24,
  parameter int         ADDR_W   = 12,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [3:0]            bus_size,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NPINS-1:0]      svc_set,
  input  logic [NPINS-1:0]      svc_clr,
  output logic [NPINS-1:0][7:0] ent_vector,
  output logic [NPINS-1:0][2:0] ent_dlv_mode,
  output logic [NPINS-1:0]      ent_dst_mode,
  output logic [NPINS-1:0]      ent_polarity,
  output logic [NPINS-1:0]      ent_inservice,
  output logic [NPINS-1:0]      ent_trigger,
  output logic [NPINS-1:0]      ent_mask,
  output logic [NPINS-1:0][7:0] ent_dest,
  output logic                  upd_valid,
  output logic [IDX_W-1:0]      upd_index
);
  // Named internal events, also seen by the bound checker
  logic [7:0]       off;
  logic             wr_ok;
  logic             sel_wr_ev;
  logic             win_wr_ev;
  logic             tab_wr_ev;
  logic             id_wr_ev;
  logic             tab_wr_hi;
  logic [IDX_W-1:0] tab_wr_idx;
  logic [31:0]      sel_q;
  logic [3:0]       id_q;
  tgt_e             tgt;
  logic [31:0]      rd_word;

  logic [NPINS-1:0][31:0] tbl_lo;
  logic [NPINS-1:0][31:0] tbl_hi;

  assign off       = bus_addr[7:0];
  assign wr_ok     = bus_wr && size_ok(bus_size);
  assign sel_wr_ev = wr_ok && (off == OFS_SEL);
  assign win_wr_ev = wr_ok && (off == OFS_WIN);
  assign tab_wr_ev = win_wr_ev && (tgt == TGT_TAB);
  assign id_wr_ev  = win_wr_ev && (tgt == TGT_ID);

  ixr_sel_decode #(.NPINS(NPINS)) dec_i (
    .sel (sel_q),
    .tgt (tgt),
    .idx (tab_wr_idx),
    .hi  (tab_wr_hi)
  );

  ixr_table #(.NPINS(NPINS)) tbl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tab_wr_ev),
    .wr_idx  (tab_wr_idx),
    .wr_hi   (tab_wr_hi),
    .wr_data (bus_wdata),
    .svc_set (svc_set),
    .svc_clr (svc_clr),
    .tbl_lo  (tbl_lo),
    .tbl_hi  (tbl_hi)
  );

  ixr_readmux #(.NPINS(NPINS), .VER_CODE(VER_CODE)) rmx_i (
    .off    (off),
    .sel_q  (sel_q),
    .id_q   (id_q),
    .tgt    (tgt),
    .idx    (tab_wr_idx),
    .hi     (tab_wr_hi),
    .tbl_lo (tbl_lo),
    .tbl_hi (tbl_hi),
    .word   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      id_q      <= '0;
      bus_rdata <= '0;
      upd_valid <= 1'b0;
      upd_index <= '0;
    end else begin
      if (sel_wr_ev) sel_q <= bus_wdata;
      if (id_wr_ev)  id_q  <= bus_wdata[B_ID_LO +: 4];
      if (bus_rd)    bus_rdata <= rd_word;
      upd_valid <= tab_wr_ev;
      if (tab_wr_ev) upd_index <= tab_wr_idx;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_fld
    assign ent_vector[g]    = tbl_lo[g][B_VEC_LO +: 8];
    assign ent_dlv_mode[g]  = tbl_lo[g][B_DLV_LO +: 3];
    assign ent_dst_mode[g]  = tbl_lo[g][B_DSTM];
    assign ent_polarity[g]  = tbl_lo[g][B_POL];
    assign ent_inservice[g] = tbl_lo[g][B_SVC];
    assign ent_trigger[g]   = tbl_lo[g][B_TRIG];
    assign ent_mask[g]      = tbl_lo[g][B_MASK];
    assign ent_dest[g]      = tbl_hi[g][B_DEST_LO +: 8];
  end
endmodule

// File: rtl/ind_route_regs_chk.sv
module ind_route_regs_chk #(
  parameter int         NPINS    = 24,
  parameter int         ADDR_W   = 12,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int IDX_W = $clog2(NPINS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [3:0]        bus_size,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       sel_q,
  input logic              tab_wr_ev,
  input logic              tab_wr_hi,
  input logic [IDX_W-1:0]  tab_wr_idx,
  input logic              upd_valid,
  input logic [IDX_W-1:0]  upd_index,
  input logic [NPINS-1:0]  ent_inservice,
  input logic [NPINS-1:0]  svc_set,
  input logic [NPINS-1:0]  svc_clr
);
  logic [7:0] off;
  logic       good_size;
  assign off       = bus_addr[7:0];
  assign good_size = (bus_size == 4'd4) || (bus_size == 4'd8);

  AST_OTHER_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && off != 8'h00 && off != 8'h10 |=> bus_rdata == 32'h0); // R1

  AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && good_size && off == 8'h00 |=> sel_q == $past(bus_wdata)); // R1

  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && off == 8'h10 && sel_q == 32'h1
    |=> bus_rdata == {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE}); // R2

  AST_LOW_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tab_wr_ev && !tab_wr_hi |=> !ent_inservice[$past(tab_wr_idx)]); // R5

  AST_HIGH_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    tab_wr_ev && tab_wr_hi && svc_set == '0 && svc_clr == '0
    |=> $stable(ent_inservice)); // R6

  AST_BAD_SIZE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !good_size |=> !upd_valid); // R9

  AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tab_wr_ev |=> upd_valid && upd_index == $past(tab_wr_idx)); // R10

  AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(tab_wr_ev)); // R10
endmodule

bind ind_route_regs ind_route_regs_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .VER_CODE(VER_CODE)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_size      (bus_size),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .sel_q         (sel_q),
  .tab_wr_ev     (tab_wr_ev),
  .tab_wr_hi     (tab_wr_hi),
  .tab_wr_idx    (tab_wr_idx),
  .upd_valid     (upd_valid),
  .upd_index     (upd_index),
  .ent_inservice (ent_inservice),
  .svc_set       (svc_set),
  .svc_clr       (svc_clr)
);

// File: tb/ind_route_regs_tb_top.sv
module ind_route_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP     = 24;
  localparam int AW     = 12;
  localparam int IW     = $clog2(NP);
  localparam logic [7:0] VCODE = 8'h11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [3:0]      bus_size = 4'd4;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   svc_set = '0;
  logic [NP-1:0]   svc_clr = '0;
  logic [NP-1:0][7:0] ent_vector;
  logic [NP-1:0][2:0] ent_dlv_mode;
  logic [NP-1:0]   ent_dst_mode, ent_polarity, ent_inservice;
  logic [NP-1:0]   ent_trigger, ent_mask;
  logic [NP-1:0][7:0] ent_dest;
  logic            upd_valid;
  logic [IW-1:0]   upd_index;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ind_route_regs #(.NPINS(NP), .ADDR_W(AW), .VER_CODE(VCODE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .svc_set(svc_set), .svc_clr(svc_clr),
    .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode),
    .ent_dst_mode(ent_dst_mode), .ent_polarity(ent_polarity),
    .ent_inservice(ent_inservice), .ent_trigger(ent_trigger),
    .ent_mask(ent_mask), .ent_dest(ent_dest),
    .upd_valid(upd_valid), .upd_index(upd_index)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [3:0] sz,
                           input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_sel(input logic [31:0] v);
    bus_write('0, 4'd4, v);
  endtask

  function automatic logic [31:0] pat_lo(input int i);
    return 32'h9E37_79B9 * 32'(i + 1);
  endfunction

  function automatic logic [31:0] pat_hi(input int i);
    return 32'h7F4A_7C15 * 32'(i + 3);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rv;
    logic [31:0] exp_id;
    logic [31:0] exp_lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    check("R8", "upd_valid after reset", 32'(upd_valid), 32'h0);
    check("R8", "mask bits after reset", 32'(ent_mask), {8'h0, {NP{1'b1}}});
    check("R8", "inservice after reset", 32'(ent_inservice), 32'h0);
    bus_read(12'h000, rv);
    check("R8", "select after reset", rv, 32'h0);
    bus_read(12'h010, rv);
    check("R8", "id after reset", rv, 32'h0);
    for (int i = 0; i < NP; i++) begin
      set_sel(32'h10 + 32'(2 * i));
      bus_read(12'h010, rv);
      check("R8", $sformatf("entry %0d low after reset", i), rv, 32'h0001_0000);
      set_sel(32'h11 + 32'(2 * i));
      bus_read(12'h010, rv);
      check("R8", $sformatf("entry %0d high after reset", i), rv, 32'h0);
    end

    // R2: version word, write discarded
    set_sel(32'h1);
    bus_read(12'h010, rv);
    check("R2", "version word", rv, (32'(NP - 1) << 16) | 32'(VCODE));
    bus_write(12'h010, 4'd4, 32'hFFFF_FFFF);
    check("R2", "no strobe on version write", 32'(upd_valid), 32'h0);
    bus_read(12'h010, rv);
    check("R2", "version after write", rv, (32'(NP - 1) << 16) | 32'(VCODE));

    // R3: ID register and its read-only mirror
    set_sel(32'h0);
    bus_write(12'h010, 4'd4, 32'hA765_4321);
    exp_id = ((32'hA765_4321 >> 24) & 32'hF) << 24;
    bus_read(12'h010, rv);
    check("R3", "id readback", rv, exp_id);
    set_sel(32'h2);
    bus_read(12'h010, rv);
    check("R3", "mirror index reads id", rv, exp_id);
    bus_write(12'h010, 4'd4, 32'h0F00_0000);
    set_sel(32'h0);
    bus_read(12'h010, rv);
    check("R3", "mirror write discarded", rv, exp_id);

    // R9: access size sweep on both locations
    for (int sz = 1; sz <= 8; sz++) begin
      bit ok;
      ok = (sz == 4) || (sz == 8);
      set_sel(32'h0);
      bus_write(12'h000, 4'(sz), 32'h0000_0033);
      bus_read(12'h000, rv);
      check("R9", $sformatf("select write size %0d", sz), rv, ok ? 32'h33 : 32'h0);
      set_sel(32'h0);
      bus_write(12'h010, 4'(sz), 32'(sz) << 24);
      if (ok) exp_id = 32'(sz) << 24;
      bus_read(12'h010, rv);
      check("R9", $sformatf("window write size %0d", sz), rv, exp_id);
    end
    set_sel(32'h10);
    bus_write(12'h010, 4'd2, 32'h0);
    check("R9", "no strobe on short table write", 32'(upd_valid), 32'h0);

    // R4, R10: fill every entry, both halves
    for (int i = 0; i < NP; i++) begin
      set_sel(32'h10 + 32'(2 * i));
      bus_write(12'h010, 4'd4, pat_lo(i));
      check("R10", $sformatf("strobe after low write %0d", i), 32'(upd_valid), 32'h1);
      check("R10", $sformatf("index after low write %0d", i), 32'(upd_index), 32'(i));
      set_sel(32'h11 + 32'(2 * i));
      bus_write(12'h010, 4'd8, pat_hi(i));
      check("R10", $sformatf("strobe after high write %0d", i), 32'(upd_valid), 32'h1);
      check("R10", $sformatf("index after high write %0d", i), 32'(upd_index), 32'(i));
      @(negedge clk);
      check("R10", "strobe lasts one cycle", 32'(upd_valid), 32'h0);
    end

    // R4, R5, R11: read back and field outputs
    for (int i = 0; i < NP; i++) begin
      exp_lo = pat_lo(i) & ~(32'h1 << 14);
      set_sel(32'h10 + 32'(2 * i));
      bus_read(12'h010, rv);
      check("R4", $sformatf("entry %0d low half", i), rv, exp_lo);
      set_sel(32'h11 + 32'(2 * i));
      bus_read(12'h010, rv);
      check("R4", $sformatf("entry %0d high half", i), rv, pat_hi(i));
      check("R11", $sformatf("vector %0d", i), 32'(ent_vector[i]), exp_lo & 32'hFF);
      check("R11", $sformatf("delivery %0d", i), 32'(ent_dlv_mode[i]), (exp_lo >> 8) & 32'h7);
      check("R11", $sformatf("dest mode %0d", i), 32'(ent_dst_mode[i]), (exp_lo >> 11) & 32'h1);
      check("R11", $sformatf("polarity %0d", i), 32'(ent_polarity[i]), (exp_lo >> 13) & 32'h1);
      check("R5", $sformatf("inservice %0d", i), 32'(ent_inservice[i]), 32'h0);
      check("R11", $sformatf("trigger %0d", i), 32'(ent_trigger[i]), (exp_lo >> 15) & 32'h1);
      check("R11", $sformatf("mask %0d", i), 32'(ent_mask[i]), (exp_lo >> 16) & 32'h1);
      check("R11", $sformatf("dest %0d", i), 32'(ent_dest[i]), pat_hi(i) >> 24);
    end

    // R1: other offsets, aliasing through upper address bits
    set_sel(32'h3E);
    for (int o = 4; o < 256; o += 4) begin
      if (o != 16) begin
        bus_write(12'(o), 4'd4, 32'hDEAD_BEEF);
        check("R1", $sformatf("no strobe offset %0h", o), 32'(upd_valid), 32'h0);
        bus_read(12'(o), rv);
        check("R1", $sformatf("offset %0h reads zero", o), rv, 32'h0);
      end
    end
    bus_read(12'h000, rv);
    check("R1", "select untouched by other offsets", rv, 32'h3E);
    bus_read(12'h310, rv);
    check("R1", "upper address bits ignored on read", rv, pat_lo(23) & ~(32'h1 << 14));
    bus_write(12'hA00, 4'd4, 32'h0000_0001);
    bus_read(12'h000, rv);
    check("R1", "upper address bits ignored on write", rv, 32'h1);

    // R7: out-of-range and unassigned selects
    for (int s = 3; s < 16; s++) begin
      set_sel(32'(s));
      bus_write(12'h010, 4'd4, 32'h1234_5678);
      check("R7", $sformatf("no strobe select %0h", s), 32'(upd_valid), 32'h0);
      bus_read(12'h010, rv);
      check("R7", $sformatf("select %0h reads zero", s), rv, 32'h0);
    end
    set_sel(32'h10 + 32'(2 * NP));
    bus_write(12'h010, 4'd4, 32'h1234_5678);
    check("R7", "no strobe first out-of-range", 32'(upd_valid), 32'h0);
    bus_read(12'h010, rv);
    check("R7", "first out-of-range reads zero", rv, 32'h0);
    set_sel(32'hFFFF_FFFF);
    bus_write(12'h010, 4'd8, 32'h1234_5678);
    check("R7", "no strobe huge select", 32'(upd_valid), 32'h0);
    set_sel(32'h10 + 32'(2 * (NP - 1)));
    bus_read(12'h010, rv);
    check("R7", "last entry intact", rv, pat_lo(NP - 1) & ~(32'h1 << 14));

    // R12, R6, R5: in-service flag
    @(negedge clk); svc_set[5] = 1'b1;
    @(negedge clk); svc_set[5] = 1'b0;
    check("R12", "set pulse", 32'(ent_inservice), 32'h20);
    set_sel(32'h10 + 32'(2 * 5) + 32'h1);
    bus_write(12'h010, 4'd4, 32'h0000_0000);
    check("R6", "high write keeps flag", 32'(ent_inservice), 32'h20);
    set_sel(32'h10 + 32'(2 * 5));
    bus_read(12'h010, rv);
    check("R5", "flag visible at bit 14", (rv >> 14) & 32'h1, 32'h1);
    bus_write(12'h010, 4'd4, 32'h0000_4000);
    check("R5", "low write clears flag", 32'(ent_inservice), 32'h0);
    bus_read(12'h010, rv);
    check("R5", "bit 14 not writable", rv, 32'h0);
    @(negedge clk); svc_set[9] = 1'b1;
    @(negedge clk); svc_set[9] = 1'b0; svc_clr[9] = 1'b1;
    @(negedge clk); svc_clr[9] = 1'b0;
    check("R12", "clear pulse", 32'(ent_inservice), 32'h0);
    @(negedge clk); svc_set[9] = 1'b1; svc_clr[9] = 1'b1;
    @(negedge clk); svc_set[9] = 1'b0; svc_clr[9] = 1'b0;
    check("R12", "clear beats set", 32'(ent_inservice), 32'h0);
    set_sel(32'h10 + 32'(2 * 9));
    @(negedge clk);
    bus_addr = 12'h010; bus_size = 4'd4; bus_wdata = 32'h0; bus_wr = 1'b1;
    svc_set[9] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; svc_set[9] = 1'b0;
    check("R12", "low write beats set", 32'(ent_inservice), 32'h0);

    finish_run();
  end
endmodule